// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recently used page table entries and turns a 32-bit virtual address into a 32-bit physical address for 4 KB pages. The virtual page number is split in two. Its low bits pick one of the sets, and its high bits are compared against the tags held in every way of that set. On a hit, the cached frame number is joined with the untouched 12-bit page offset. The low twelve flag bits of the entry are returned as well, and the access is checked against the user and write permissions of the entry.

On a miss the block raises a refill request. An external table walker answers by presenting the virtual address and the page table entry it found. The block keeps the whole entry, flags included. A task-switch flush drops every entry that is not marked global. A full flush drops everything in one cycle.

A lookup is resolved combinationally and registered, so its result is visible in the cycle after it is presented.

Top module: `xlate_cache`

## Requirements
- R1: After reset, res_valid and refill_req are 0 and every entry is invalid, so the first lookup misses.
- R2: A lookup that is accepted (lk_valid high with no refill and no flush in that cycle) gives res_valid=1 in the next cycle. res_hit=1 exactly when a valid entry in set vaddr[15:12] holds the tag vaddr[31:16].
- R3: On a hit, res_paddr = {pte[31:12], vaddr[11:0]} and res_flags = pte[11:0]. On a miss, both are zero.
- R4: A miss result has res_hit=0, res_fault=0 and refill_req=1. refill_req is 0 on a hit and whenever res_valid is 0.
- R5: On a hit, res_fault=1 when (lk_user=1 and pte bit 2 = 0) or (lk_write=1 and pte bit 1 = 0). Otherwise it is 0.
- R6: A refill writes {valid, tag, pte} into the set indexed by rf_vaddr[15:12]. A lookup presented in the same cycle is dropped, so res_valid=0 in the next cycle.
- R7: The refill chooses its way in this order. First, a way already holding the same tag is overwritten. Next, the lowest-numbered invalid way is used. Otherwise the set's round-robin pointer picks the way. The pointer starts at way 0 and advances by one, modulo the way count, only on such an eviction.
- R8: task_flush invalidates, in one cycle, every entry whose pte bit 8 (global) is 0, and keeps the global ones.
- R9: full_flush invalidates every entry, global ones included, in one cycle.
- R10: Priority is full_flush, then task_flush, then refill, then lookup. A refill that arrives together with a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_user | input | 1 | Access made in user mode |
| lk_write | input | 1 | Access is a write |
| rf_valid | input | 1 | Refill from the walker |
| rf_vaddr | input | 32 | Virtual address of the refilled page |
| rf_pte | input | 32 | Page table entry to cache |
| task_flush | input | 1 | Drop all non-global entries |
| full_flush | input | 1 | Drop all entries |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup found an entry |
| res_paddr | output | 32 | Translated physical address |
| res_flags | output | 12 | Low flag bits of the hit entry |
| res_fault | output | 1 | Permission violation on a hit |
| refill_req | output | 1 | Miss: walker must supply an entry |

## Verification
The bench fills one set past capacity and checks which tags survive. A design whose round-robin pointer moved on every refill, or that ignored invalid ways, would evict the wrong tag. The bench re-refills a tag that is already cached. A design that did not overwrite it in place would evict a live neighbour. The bench also flushes a set holding a mix of global and non-global entries, and presents a refill and a lookup together with flushes. A design that got the priority wrong would report a result for the dropped lookup or keep the discarded entry. Permission checks cover supervisor-only and read-only pages on the same hit path.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int PTE_W  = 32;
    localparam int FLAG_W = 12;
    localparam int G_BIT  = 8;
    localparam int US_BIT = 2;
    localparam int RW_BIT = 1;

    function automatic logic prot_fault(input logic [PTE_W-1:0] pte,
                                        input logic usr, input logic wr);
        return (usr && !pte[US_BIT]) || (wr && !pte[RW_BIT]);
    endfunction
endpackage

// File: rtl/xlate_match.sv
module xlate_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int PTE_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][PTE_W-1:0]  way_pte,
    input  logic [TAG_W-1:0]            key_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [PTE_W-1:0]            hit_pte
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == key_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
        hit     = |match;
        hit_pte = way_pte[hit_way];
    end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic             same_tag,
    input  logic [WAY_W-1:0] same_way,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             evict
);
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = rr_ptr;
        evict  = 1'b0;
        if (same_tag) begin
            victim = same_way;
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!way_valid[w]) begin
                    victim = WAY_W'(w);
                    found  = 1'b1;
                end
            end
            if (!found) begin
                victim = rr_ptr;
                evict  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xlate_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_user,
    input  logic              lk_write,
    input  logic              rf_valid,
    input  logic [VA_W-1:0]   rf_vaddr,
    input  logic [PTE_W-1:0]  rf_pte,
    input  logic              task_flush,
    input  logic              full_flush,
    output logic              res_valid,
    output logic              res_hit,
    output logic [VA_W-1:0]   res_paddr,
    output logic [FLAG_W-1:0] res_flags,
    output logic              res_fault,
    output logic              refill_req
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PFN_W = PTE_W - OFF_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PTE_W-1:0] pte;
    } ent_t;

    typedef struct packed {
        ent_t [SETS-1:0][WAYS-1:0]  ents;
        logic [SETS-1:0][WAY_W-1:0] rr;
        logic                       rv;
        logic                       rh;
        logic                       rflt;
        logic [VA_W-1:0]            pa;
        logic [FLAG_W-1:0]          fl;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic [TAG_W-1:0] lk_tag, rf_tag;
    assign lk_idx = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[OFF_W+IDX_W +: TAG_W];
    assign rf_idx = rf_vaddr[OFF_W +: IDX_W];
    assign rf_tag = rf_vaddr[OFF_W+IDX_W +: TAG_W];

    logic [WAYS-1:0]            lk_v, rf_v;
    logic [WAYS-1:0][TAG_W-1:0] lk_t, rf_t;
    logic [WAYS-1:0][PTE_W-1:0] lk_p, rf_p;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_v[w] = st_q.ents[lk_idx][w].valid;
            lk_t[w] = st_q.ents[lk_idx][w].tag;
            lk_p[w] = st_q.ents[lk_idx][w].pte;
            rf_v[w] = st_q.ents[rf_idx][w].valid;
            rf_t[w] = st_q.ents[rf_idx][w].tag;
            rf_p[w] = st_q.ents[rf_idx][w].pte;
        end
    end

    logic             lk_hit, rf_same;
    logic [WAY_W-1:0] lk_way, rf_same_way, rf_victim;
    logic [PTE_W-1:0] lk_pte, rf_unused_pte;
    logic             rf_evict;

    xlate_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_lk_match (
        .way_valid(lk_v), .way_tag(lk_t), .way_pte(lk_p), .key_tag(lk_tag),
        .hit(lk_hit), .hit_way(lk_way), .hit_pte(lk_pte)
    );

    xlate_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_rf_match (
        .way_valid(rf_v), .way_tag(rf_t), .way_pte(rf_p), .key_tag(rf_tag),
        .hit(rf_same), .hit_way(rf_same_way), .hit_pte(rf_unused_pte)
    );

    xlate_victim #(.WAYS(WAYS)) u_victim (
        .way_valid(rf_v), .same_tag(rf_same), .same_way(rf_same_way),
        .rr_ptr(st_q.rr[rf_idx]), .victim(rf_victim), .evict(rf_evict)
    );

    logic lk_accept;
    assign lk_accept = lk_valid && !rf_valid && !task_flush && !full_flush;

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        st_d.rh   = 1'b0;
        st_d.rflt = 1'b0;
        st_d.pa   = '0;
        st_d.fl   = '0;

        if (full_flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    st_d.ents[s][w].valid = 1'b0;
        end else if (task_flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (!st_q.ents[s][w].pte[G_BIT])
                        st_d.ents[s][w].valid = 1'b0;
        end else if (rf_valid) begin
            st_d.ents[rf_idx][rf_victim] = ent_t'{valid: 1'b1, tag: rf_tag, pte: rf_pte};
            if (rf_evict)
                st_d.rr[rf_idx] = (st_q.rr[rf_idx] == WAY_W'(WAYS - 1))
                                  ? '0 : st_q.rr[rf_idx] + WAY_W'(1);
        end

        if (lk_accept) begin
            st_d.rv = 1'b1;
            if (lk_hit) begin
                st_d.rh   = 1'b1;
                st_d.pa   = {lk_pte[PTE_W-1 -: PFN_W], lk_vaddr[OFF_W-1:0]};
                st_d.fl   = lk_pte[FLAG_W-1:0];
                st_d.rflt = prot_fault(lk_pte, lk_user, lk_write);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.rv;
    assign res_hit    = st_q.rh;
    assign res_paddr  = st_q.pa;
    assign res_flags  = st_q.fl;
    assign res_fault  = st_q.rflt;
    assign refill_req = st_q.rv && !st_q.rh;
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk
    import xlate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              rf_valid,
    input logic              task_flush,
    input logic              full_flush,
    input logic              res_valid,
    input logic              res_hit,
    input logic [VA_W-1:0]   res_paddr,
    input logic              res_fault,
    input logic              refill_req
);
    logic acc;
    assign acc = lk_valid && !rf_valid && !task_flush && !full_flush;

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> res_valid);

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!res_hit || res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    assert_refill_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (res_valid && !res_hit));

    assert_fault_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_hit);

    assert_lookup_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid || task_flush || full_flush) |=> !res_valid);

    assert_full_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flush ##1 acc) |=> !res_hit);
endmodule

bind xlate_cache xlate_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .rf_valid(rf_valid), .task_flush(task_flush), .full_flush(full_flush),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
    .res_fault(res_fault), .refill_req(refill_req)
);

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid = 0, lk_user = 0, lk_write = 0;
    logic [31:0] lk_vaddr = '0;
    logic        rf_valid = 0;
    logic [31:0] rf_vaddr = '0, rf_pte = '0;
    logic        task_flush = 0, full_flush = 0;
    logic        res_valid, res_hit, res_fault, refill_req;
    logic [31:0] res_paddr;
    logic [11:0] res_flags;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_user(lk_user), .lk_write(lk_write), .rf_valid(rf_valid),
        .rf_vaddr(rf_vaddr), .rf_pte(rf_pte), .task_flush(task_flush),
        .full_flush(full_flush), .res_valid(res_valid), .res_hit(res_hit),
        .res_paddr(res_paddr), .res_flags(res_flags), .res_fault(res_fault),
        .refill_req(refill_req)
    );

    typedef struct packed {
        logic        is_lk;
        logic [31:0] va;
        logic [31:0] pte;
        logic        usr;
        logic        wr;
        logic        ehit;
        logic [31:0] epa;
        logic        eflt;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{1'b0, 32'h1234_5000, 32'hABCD_E007, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{1'b0, 32'h0000_3000, 32'h1111_1003, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{1'b0, 32'hFFFF_F000, 32'h2222_2105, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{1'b1, 32'h1234_5ABC, 32'h0, 1'b1, 1'b1, 1'b1, 32'hABCD_EABC, 1'b0},
        '{1'b1, 32'h1235_5000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{1'b1, 32'h1234_6000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0},
        '{1'b1, 32'h0000_3010, 32'h0, 1'b1, 1'b0, 1'b1, 32'h1111_1010, 1'b1},
        '{1'b1, 32'h0000_3010, 32'h0, 1'b0, 1'b1, 1'b1, 32'h1111_1010, 1'b0},
        '{1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 1'b1, 32'h2222_2FFF, 1'b1},
        '{1'b1, 32'hFFFF_F001, 32'h0, 1'b1, 1'b0, 1'b1, 32'h2222_2001, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic refill(input logic [31:0] va, input logic [31:0] pte);
        @(negedge clk);
        rf_valid = 1; rf_vaddr = va; rf_pte = pte;
        @(negedge clk);
        rf_valid = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic u, input logic w);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_user = u; lk_write = w;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] va, input logic e);
        look(va, 1'b0, 1'b0);
        chk(req, {31'b0, res_hit}, {31'b0, e});
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all R): actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
        chk("R1 refill_req", {31'b0, refill_req}, 32'd0);
        look(32'h1234_5000, 1'b0, 1'b0);
        chk("R1 empty miss", {31'b0, res_hit}, 32'd0);

        // R2 R3 R4 R5 vector table
        foreach (TBL[i]) begin
            if (!TBL[i].is_lk) begin
                refill(TBL[i].va, TBL[i].pte);
            end else begin
                look(TBL[i].va, TBL[i].usr, TBL[i].wr);
                chk("R2 res_valid", {31'b0, res_valid}, 32'd1);
                chk("R2 hit", {31'b0, res_hit}, {31'b0, TBL[i].ehit});
                chk("R3 paddr", res_paddr, TBL[i].epa);
                chk("R4 refill_req", {31'b0, refill_req}, {31'b0, !TBL[i].ehit});
                chk("R5 fault", {31'b0, res_fault}, {31'b0, TBL[i].eflt});
            end
        end
        look(32'h1234_5000, 1'b0, 1'b0);
        chk("R3 flags", {20'b0, res_flags}, 32'h007);
        look(32'h1234_7000, 1'b0, 1'b0);
        chk("R3 miss flags zero", {20'b0, res_flags}, 32'h0);

        // R6 refill and lookup in the same cycle
        @(negedge clk);
        rf_valid = 1; rf_vaddr = 32'h0000_4000; rf_pte = 32'h4444_4003;
        lk_valid = 1; lk_vaddr = 32'h1234_5000;
        @(negedge clk);
        rf_valid = 0; lk_valid = 0;
        chk("R6 lookup dropped", {31'b0, res_valid}, 32'd0);
        look(32'h0000_4123, 1'b0, 1'b0);
        chk("R6 refilled paddr", res_paddr, 32'h4444_4123);

        // R7 replacement in set 9
        for (int k = 1; k <= 4; k++)
            refill({16'(k), 4'h9, 12'h0}, {20'(k), 12'h001});
        for (int k = 1; k <= 4; k++)
            expect_hit("R7 fill", {16'(k), 4'h9, 12'h0}, 1'b1);
        refill({16'd5, 4'h9, 12'h0}, {20'd5, 12'h001});
        expect_hit("R7 evict way0", {16'd1, 4'h9, 12'h0}, 1'b0);
        for (int k = 2; k <= 5; k++)
            expect_hit("R7 survivors", {16'(k), 4'h9, 12'h0}, 1'b1);
        refill({16'd6, 4'h9, 12'h0}, {20'd6, 12'h001});
        expect_hit("R7 evict way1", {16'd2, 4'h9, 12'h0}, 1'b0);
        refill({16'd3, 4'h9, 12'h0}, 32'h3333_3001);
        look({16'd3, 4'h9, 12'h0}, 1'b0, 1'b0);
        chk("R7 overwrite in place", res_paddr, 32'h3333_3000);
        for (int k = 4; k <= 6; k++)
            expect_hit("R7 no eviction on overwrite", {16'(k), 4'h9, 12'h0}, 1'b1);
        refill({16'd7, 4'h9, 12'h0}, {20'd7, 12'h001});
        expect_hit("R7 evict way2", {16'd3, 4'h9, 12'h0}, 1'b0);
        expect_hit("R7 way3 kept", {16'd4, 4'h9, 12'h0}, 1'b1);

        // R8 task flush keeps global entries
        @(negedge clk); task_flush = 1;
        @(negedge clk); task_flush = 0;
        expect_hit("R8 non-global dropped", 32'h1234_5000, 1'b0);
        expect_hit("R8 global kept", 32'hFFFF_F000, 1'b1);

        // R10 refill plus lookup with a flush
        @(negedge clk);
        task_flush = 1; rf_valid = 1; rf_vaddr = 32'h0000_7000; rf_pte = 32'h7777_7107;
        lk_valid = 1; lk_vaddr = 32'hFFFF_F000;
        @(negedge clk);
        task_flush = 0; rf_valid = 0; lk_valid = 0;
        chk("R10 lookup dropped", {31'b0, res_valid}, 32'd0);
        expect_hit("R10 refill discarded", 32'h0000_7000, 1'b0);

        // R9 full flush
        @(negedge clk); full_flush = 1;
        @(negedge clk); full_flush = 0;
        expect_hit("R9 global dropped", 32'hFFFF_F000, 1'b0);
        chk("R9 refill_req", {31'b0, refill_req}, 32'd1);

        finish_run();
    end
endmodule